// File: doc/BRIEF.md
# Secure Session Privilege Tracker

This block keeps the security standing of one host session and turns it into per-zone access grants. It does no cryptography and stores no data. Neighbouring logic performs password comparison, challenge-response authentication, encryption activation and message authentication code (MAC) checks, then reports each outcome as a one-cycle strobe. The tracker remembers the latest password credential, the current session mode and the key used, and counts failed attempts per credential. Once a credential has failed too often, every later attempt with it is refused.

A small zone requirement table arrives on input ports. For each zone it gives:
- an optional password-set requirement;
- an optional authentication requirement;
- an optional encryption requirement;
- the key the zone is tied to.

The read and write grant flags for each zone are derived combinationally from the registered session state and this table. A grant therefore changes in the first cycle after the event that caused it.

Top module: `sess_priv_mgr`

## Requirements
- R1: After power-on reset (`rst_n` low), `mode` is 2'b00 (standard) and `pw_active`, `pw_set`, `pw_write` and `key_cur` are all zero. Only zones with no requirement flag set show read and write grants.
- R2: On `pw_ok` for a usable set, `pw_active` goes to 1, `pw_set` takes `pw_sel` and `pw_write` takes `pw_is_wr`, all from the next cycle. Any earlier password is replaced, so only one set is ever active.
- R3: A password-protected zone is readable when its set is active with either type. It is writable only when that set is active as a write password (`pw_write`=1). Write access therefore implies read access.
- R4: A failed presentation (`pw_fail`, or `pw_ok` for a locked set) clears `pw_active` and `pw_write`, and `pw_set` shows the presented index.
- R5: `auth_ok` for a usable key moves `mode` to 2'b01 (authenticated) and sets `key_cur` to `auth_key`. `auth_fail`, or `auth_ok` for a locked key, sets `key_cur` to `auth_key` and drops `mode` to 2'b00, discarding any earlier authentication.
- R6: `enc_ok` moves `mode` to 2'b10 (encrypted) only from 2'b01 or 2'b10. In standard mode it has no effect.
- R7: `mac_bad` in mode 2'b01 or 2'b10 returns `mode` to 2'b00 in the next cycle. The password state is kept. `mac_bad` takes priority over authentication and encryption strobes in the same cycle.
- R8: Each password set and each key has a saturating failure counter. After TRY_LIMIT (default 4) failures in a row, the credential is locked and its successes count as failures. A success before the limit resets the counter to zero.
- R9: `card_rst` clears password, authentication, mode and key state in the next cycle, as R1 does. Failure counters and locks are kept.
- R10: A zone flagged for authentication is granted only in mode 2'b01 or 2'b10 with `key_cur` equal to its key. A zone flagged for encryption is granted only in mode 2'b10 with its key. These conditions are combined by AND with the zone's password condition.
- R11: Grants are a combinational function of registered state. A strobe sampled at clock edge N is reflected in `zone_rd`/`zone_wr` after edge N and before edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears everything |
| card_rst | input | 1 | Session reset strobe, keeps failure counters |
| pw_ok | input | 1 | Password comparison succeeded |
| pw_fail | input | 1 | Password comparison failed |
| pw_sel | input | PW_W | Password set index of the attempt |
| pw_is_wr | input | 1 | 1 = write password, 0 = read password |
| auth_ok | input | 1 | Authentication succeeded |
| auth_fail | input | 1 | Authentication failed |
| auth_key | input | KEY_W | Key index of the authentication attempt |
| enc_ok | input | 1 | Encryption activation succeeded |
| mac_bad | input | 1 | MAC mismatch on an incoming command |
| zone_need_pw | input | NUM_ZONE | Per zone: password required |
| zone_pw_sel | input | NUM_ZONE*PW_W | Per zone: required password set |
| zone_need_auth | input | NUM_ZONE | Per zone: authentication required |
| zone_need_enc | input | NUM_ZONE | Per zone: encryption required |
| zone_key_sel | input | NUM_ZONE*KEY_W | Per zone: selected key |
| mode | output | 2 | 00 standard, 01 authenticated, 10 encrypted |
| pw_active | output | 1 | A password is currently active |
| pw_set | output | PW_W | Index of the last presented password set |
| pw_write | output | 1 | Active password is a write password |
| key_cur | output | KEY_W | Key of the latest authentication attempt |
| zone_rd | output | NUM_ZONE | Per zone read grant |
| zone_wr | output | NUM_ZONE | Per zone write grant |

## Verification
The assertions assume that at most one of the event classes occurs in any cycle: a password event, an authentication event, an encryption activation, a MAC mismatch, or a session reset. They also assume that `pw_ok` and `pw_fail` never assert together, and that `auth_ok` and `auth_fail` never assert together. The stimulus drives one event per step from a single task, which keeps it within these assumptions. The zone table stays constant for the whole run, so grant changes come only from state updates. Lockout is exercised by issuing repeated failures on a single credential.

// File: rtl/sess_priv_pkg.sv
package sess_priv_pkg;
    typedef enum logic [1:0] {
        MODE_STD  = 2'b00,
        MODE_AUTH = 2'b01,
        MODE_ENC  = 2'b10
    } sess_mode_e;
endpackage

// File: rtl/sess_try_ctr.sv
// Bank of saturating failure counters, one per credential.
module sess_try_ctr #(
    parameter int N         = 8,
    parameter int TRY_LIMIT = 4,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W    = $clog2(TRY_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_ok,
    input  logic             ev_fail,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     locked
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TRY_LIMIT);

    logic [CNT_W-1:0] cnt_d [N];
    logic [CNT_W-1:0] cnt_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cnt_d[i] = cnt_q[i];
            if ((ev_ok || ev_fail) && (idx == IDX_W'(i))) begin
                if (ev_ok && (cnt_q[i] < LIM))
                    cnt_d[i] = '0;
                else if (cnt_q[i] < LIM)
                    cnt_d[i] = cnt_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) cnt_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) cnt_q[i] <= cnt_d[i];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_lock
        assign locked[g] = (cnt_q[g] >= LIM);

        // R8: a counter never passes the limit
        p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] <= LIM);
        // R8: a locked credential stays locked until power-on reset
        p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            locked[g] |=> locked[g]);
    end
endmodule

// File: rtl/sess_zone_grant.sv
// Per-zone grant decode from session state and the zone requirement table.
module sess_zone_grant
    import sess_priv_pkg::*;
#(
    parameter int NUM_ZONE = 4,
    parameter int PW_W     = 3,
    parameter int KEY_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  sess_mode_e                mode,
    input  logic                      pw_act,
    input  logic [PW_W-1:0]           pw_set,
    input  logic                      pw_wr,
    input  logic [KEY_W-1:0]          key,
    input  logic [NUM_ZONE-1:0]       need_pw,
    input  logic [NUM_ZONE*PW_W-1:0]  pw_tab,
    input  logic [NUM_ZONE-1:0]       need_auth,
    input  logic [NUM_ZONE-1:0]       need_enc,
    input  logic [NUM_ZONE*KEY_W-1:0] key_tab,
    output logic [NUM_ZONE-1:0]       rd,
    output logic [NUM_ZONE-1:0]       wr
);
    for (genvar z = 0; z < NUM_ZONE; z++) begin : g_zone
        logic set_hit, pw_rd_ok, pw_wr_ok, key_hit, sec_ok;

        always_comb begin
            set_hit  = pw_act && (pw_set == pw_tab[z*PW_W +: PW_W]);
            pw_rd_ok = !need_pw[z] || set_hit;
            pw_wr_ok = !need_pw[z] || (set_hit && pw_wr);
            key_hit  = (mode != MODE_STD) && (key == key_tab[z*KEY_W +: KEY_W]);
            if (need_enc[z])
                sec_ok = key_hit && (mode == MODE_ENC);
            else if (need_auth[z])
                sec_ok = key_hit;
            else
                sec_ok = 1'b1;
        end

        assign rd[z] = pw_rd_ok && sec_ok;
        assign wr[z] = pw_wr_ok && sec_ok;

        // R10: an encryption zone is never readable outside encrypted mode
        p_enc_zone_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (need_enc[z] && rd[z]) |-> (mode == MODE_ENC));
    end

    // R3: a write grant is always accompanied by a read grant
    p_wr_has_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr & ~rd) == '0);
endmodule

// File: rtl/sess_priv_mgr.sv
module sess_priv_mgr
    import sess_priv_pkg::*;
#(
    parameter int NUM_PW    = 8,
    parameter int NUM_KEY   = 4,
    parameter int NUM_ZONE  = 4,
    parameter int TRY_LIMIT = 4,
    localparam int PW_W     = $clog2(NUM_PW),
    localparam int KEY_W    = $clog2(NUM_KEY)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      card_rst,
    input  logic                      pw_ok,
    input  logic                      pw_fail,
    input  logic [PW_W-1:0]           pw_sel,
    input  logic                      pw_is_wr,
    input  logic                      auth_ok,
    input  logic                      auth_fail,
    input  logic [KEY_W-1:0]          auth_key,
    input  logic                      enc_ok,
    input  logic                      mac_bad,
    input  logic [NUM_ZONE-1:0]       zone_need_pw,
    input  logic [NUM_ZONE*PW_W-1:0]  zone_pw_sel,
    input  logic [NUM_ZONE-1:0]       zone_need_auth,
    input  logic [NUM_ZONE-1:0]       zone_need_enc,
    input  logic [NUM_ZONE*KEY_W-1:0] zone_key_sel,
    output logic [1:0]                mode,
    output logic                      pw_active,
    output logic [PW_W-1:0]           pw_set,
    output logic                      pw_write,
    output logic [KEY_W-1:0]          key_cur,
    output logic [NUM_ZONE-1:0]       zone_rd,
    output logic [NUM_ZONE-1:0]       zone_wr
);
    typedef struct packed {
        sess_mode_e       mode;
        logic             pw_act;
        logic [PW_W-1:0]  pw_set;
        logic             pw_wr;
        logic [KEY_W-1:0] key;
    } sess_st_t;

    sess_st_t st_d, st_q;
    logic [NUM_PW-1:0]  pw_lock;
    logic [NUM_KEY-1:0] key_lock;
    logic               pw_good, auth_good;

    sess_try_ctr #(.N(NUM_PW), .TRY_LIMIT(TRY_LIMIT)) u_pw_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_ok   (pw_ok && !card_rst),
        .ev_fail (pw_fail && !card_rst),
        .idx     (pw_sel),
        .locked  (pw_lock)
    );

    sess_try_ctr #(.N(NUM_KEY), .TRY_LIMIT(TRY_LIMIT)) u_key_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_ok   (auth_ok && !card_rst),
        .ev_fail (auth_fail && !card_rst),
        .idx     (auth_key),
        .locked  (key_lock)
    );

    always_comb begin
        st_d      = st_q;
        pw_good   = pw_ok && !pw_lock[pw_sel];
        auth_good = auth_ok && !key_lock[auth_key];
        if (card_rst) begin
            st_d      = '0;
            st_d.mode = MODE_STD;
        end else begin
            if (pw_ok || pw_fail) begin
                st_d.pw_act = pw_good;
                st_d.pw_set = pw_sel;
                st_d.pw_wr  = pw_good && pw_is_wr;
            end
            if (mac_bad) begin
                st_d.mode = MODE_STD;
            end else if (auth_ok || auth_fail) begin
                st_d.key  = auth_key;
                st_d.mode = auth_good ? MODE_AUTH : MODE_STD;
            end else if (enc_ok && (st_q.mode != MODE_STD)) begin
                st_d.mode = MODE_ENC;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_STD;
        end else begin
            st_q <= st_d;
        end
    end

    sess_zone_grant #(.NUM_ZONE(NUM_ZONE), .PW_W(PW_W), .KEY_W(KEY_W)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (st_q.mode),
        .pw_act    (st_q.pw_act),
        .pw_set    (st_q.pw_set),
        .pw_wr     (st_q.pw_wr),
        .key       (st_q.key),
        .need_pw   (zone_need_pw),
        .pw_tab    (zone_pw_sel),
        .need_auth (zone_need_auth),
        .need_enc  (zone_need_enc),
        .key_tab   (zone_key_sel),
        .rd        (zone_rd),
        .wr        (zone_wr)
    );

    assign mode      = st_q.mode;
    assign pw_active = st_q.pw_act;
    assign pw_set    = st_q.pw_set;
    assign pw_write  = st_q.pw_wr;
    assign key_cur   = st_q.key;

    // R6: encrypted mode is never reached directly from standard mode
    p_no_enc_from_std_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD) |=> (mode != MODE_ENC));
    // R7: a MAC mismatch always leaves the session in standard mode
    p_mac_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mac_bad |=> (mode == MODE_STD));
    // R5: a failed authentication leaves no authenticated mode behind
    p_auth_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        auth_fail |=> (mode == MODE_STD));
    // R9: session reset clears password and mode
    p_card_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |=> (!pw_active && !pw_write && mode == MODE_STD));
    // R2: a write flag never exists without an active password
    p_wr_needs_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pw_write |-> pw_active);
endmodule

// File: tb/sess_priv_mgr_test.sv
module sess_priv_mgr_test;
    localparam int NZ  = 4;
    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 0, pw_ok = 0, pw_fail = 0, pw_is_wr = 0;
    logic auth_ok = 0, auth_fail = 0, enc_ok = 0, mac_bad = 0;
    logic [2:0] pw_sel = 0;
    logic [1:0] auth_key = 0;
    // zone table: z0 open, z1 needs set 2, z2 needs auth key 1,
    // z3 needs encryption with key 3 and set 5
    logic [NZ-1:0]   t_need_pw   = 4'b1010;
    logic [NZ*3-1:0] t_pw_sel    = {3'd5, 3'd0, 3'd2, 3'd0};
    logic [NZ-1:0]   t_need_auth = 4'b0100;
    logic [NZ-1:0]   t_need_enc  = 4'b1000;
    logic [NZ*2-1:0] t_key_sel   = {2'd3, 2'd1, 2'd0, 2'd0};

    logic [1:0]    mode;
    logic          pw_active, pw_write;
    logic [2:0]    pw_set;
    logic [1:0]    key_cur;
    logic [NZ-1:0] zone_rd, zone_wr;

    sess_priv_mgr uut (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
        .pw_ok(pw_ok), .pw_fail(pw_fail), .pw_sel(pw_sel), .pw_is_wr(pw_is_wr),
        .auth_ok(auth_ok), .auth_fail(auth_fail), .auth_key(auth_key),
        .enc_ok(enc_ok), .mac_bad(mac_bad),
        .zone_need_pw(t_need_pw), .zone_pw_sel(t_pw_sel),
        .zone_need_auth(t_need_auth), .zone_need_enc(t_need_enc),
        .zone_key_sel(t_key_sel),
        .mode(mode), .pw_active(pw_active), .pw_set(pw_set), .pw_write(pw_write),
        .key_cur(key_cur), .zone_rd(zone_rd), .zone_wr(zone_wr)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [1:0]    mode;
        logic          pwv;
        logic [2:0]    pws;
        logic          pww;
        logic [1:0]    key;
        logic [NZ-1:0] rd;
        logic [NZ-1:0] wr;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_mode; logic m_pwv; logic [2:0] m_pws; logic m_pww; logic [1:0] m_key;
    int pcnt[8]; int kcnt[4];

    task automatic model_power_reset();
        m_mode = 0; m_pwv = 0; m_pws = 0; m_pww = 0; m_key = 0;
        foreach (pcnt[i]) pcnt[i] = 0;
        foreach (kcnt[i]) kcnt[i] = 0;
    endtask

    function automatic exp_t model_out(string tag);
        exp_t e;
        e.mode = m_mode; e.pwv = m_pwv; e.pws = m_pws; e.pww = m_pww; e.key = m_key;
        e.tag = tag;
        for (int z = 0; z < NZ; z++) begin
            bit hit, prd, pwr, sec;
            hit = m_pwv && (m_pws == t_pw_sel[z*3 +: 3]);
            prd = !t_need_pw[z] || hit;
            pwr = !t_need_pw[z] || (hit && m_pww);
            if (t_need_enc[z])       sec = (m_mode == 2'b10) && (m_key == t_key_sel[z*2 +: 2]);
            else if (t_need_auth[z]) sec = (m_mode != 2'b00) && (m_key == t_key_sel[z*2 +: 2]);
            else                     sec = 1;
            e.rd[z] = prd && sec;
            e.wr[z] = pwr && sec;
        end
        return e;
    endfunction

    // ev: 0 idle, 1 card_rst, 2 pw_ok, 3 pw_fail, 4 auth_ok, 5 auth_fail, 6 enc_ok, 7 mac_bad
    task automatic step(int ev, int sel, bit wrt, string tag);
        @(negedge clk);
        card_rst  = (ev == 1);
        pw_ok     = (ev == 2);
        pw_fail   = (ev == 3);
        auth_ok   = (ev == 4);
        auth_fail = (ev == 5);
        enc_ok    = (ev == 6);
        mac_bad   = (ev == 7);
        pw_sel    = 3'(sel);
        auth_key  = 2'(sel);
        pw_is_wr  = wrt;
        case (ev)
            1: begin m_mode = 0; m_pwv = 0; m_pws = 0; m_pww = 0; m_key = 0; end
            2, 3: begin
                bit good;
                good = (ev == 2) && (pcnt[sel] < LIM);
                if (good) pcnt[sel] = 0; else if (pcnt[sel] < LIM) pcnt[sel]++;
                m_pwv = good; m_pws = 3'(sel); m_pww = good && wrt;
            end
            4, 5: begin
                bit good;
                good = (ev == 4) && (kcnt[sel] < LIM);
                if (good) kcnt[sel] = 0; else if (kcnt[sel] < LIM) kcnt[sel]++;
                m_key = 2'(sel); m_mode = good ? 2'b01 : 2'b00;
            end
            6: if (m_mode != 0) m_mode = 2'b10;
            7: m_mode = 0;
            default: ;
        endcase
        @(posedge clk); #1;
        q.push_back(model_out(tag));
        card_rst = 0; pw_ok = 0; pw_fail = 0; auth_ok = 0; auth_fail = 0;
        enc_ok = 0; mac_bad = 0;
    endtask

    task automatic power_reset(string tag);
        while (q.size() > 0) @(negedge clk);
        @(negedge clk); rst_n = 0;
        model_power_reset();
        @(posedge clk); #1;
        q.push_back(model_out(tag));
        @(negedge clk); rst_n = 1;
    endtask

    // monitor: compares one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (mode !== e.mode || pw_active !== e.pwv || pw_set !== e.pws ||
                    pw_write !== e.pww || key_cur !== e.key ||
                    zone_rd !== e.rd || zone_wr !== e.wr) begin
                    errors++;
                    $display("FAIL %s: got mode=%b act=%b set=%0d wr=%b key=%0d rd=%b wrg=%b exp mode=%b act=%b set=%0d wr=%b key=%0d rd=%b wrg=%b",
                             e.tag, mode, pw_active, pw_set, pw_write, key_cur, zone_rd, zone_wr,
                             e.mode, e.pwv, e.pws, e.pww, e.key, e.rd, e.wr);
                end
            end
        end
    end

    initial begin
        model_power_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(0, 0, 0, "R1 reset state, only open zone granted");
        step(2, 2, 0, "R2 read password set 2 active");
        step(2, 2, 1, "R3 write password set 2 grants read and write");
        step(2, 5, 1, "R2 new set 5 replaces set 2");
        step(3, 5, 0, "R4 failed presentation clears password");
        step(4, 1, 0, "R5 auth key 1 grants auth zone R10");
        step(6, 0, 0, "R6 encryption from authenticated");
        step(7, 0, 0, "R7 MAC mismatch drops to standard");
        step(6, 0, 0, "R6 encryption ignored in standard");
        step(2, 5, 1, "R3 write set 5 for encrypted zone");
        step(4, 3, 0, "R10 auth key 3 alone not enough for encryption zone");
        step(6, 0, 0, "R10 encrypted key 3 grants zone 3");
        step(7, 0, 0, "R7 MAC mismatch keeps password");
        step(4, 1, 0, "R5 auth key 1 again");
        step(5, 1, 0, "R5 failed re-authentication revokes");
        step(4, 1, 0, "R5 auth key 1 before session reset");
        step(1, 0, 0, "R9 session reset clears state");
        for (int i = 0; i < LIM; i++) step(3, 2, 0, "R8 failure on set 2");
        step(2, 2, 1, "R8 locked set 2 refuses success");
        step(1, 0, 0, "R9 session reset");
        step(2, 2, 1, "R9 lock on set 2 survives session reset");
        for (int i = 0; i < LIM - 1; i++) step(3, 5, 0, "R8 failure below limit on set 5");
        step(2, 5, 0, "R8 success below limit accepted");
        for (int i = 0; i < LIM - 1; i++) step(3, 5, 0, "R8 counter restarted after success");
        step(2, 5, 1, "R8 success still accepted after reset count");
        for (int i = 0; i < LIM; i++) step(5, 3, 0, "R8 failure on key 3");
        step(4, 3, 0, "R8 locked key 3 refuses authentication");
        step(4, 1, 0, "R11 other key still usable");
        power_reset("R1 power-on reset clears state");
        step(2, 2, 1, "R1 power-on reset clears lock on set 2");
        step(4, 3, 0, "R1 power-on reset clears lock on key 3");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule